// File: doc/BRIEF.md
# PHY Station Management Controller

This block lets a host reach the management registers of one Ethernet PHY over the two-wire MDC/MDIO serial link, using clause-22 frames. The host sees a single 32-bit word. Writing it with an operation bit set launches one transaction, and the host then polls the busy flag until the frame has finished. After a read, the same word returns the 16 bits taken from the PHY and a not-valid flag. That flag says whether the PHY actually answered.

MDC is made inside the system clock domain by a parameterised divider. Each frame is 64 bits long. MDIO changes while MDC is low, and the block samples MDIO on each MDC rising edge. In a read, the block releases the line from the turnaround onward, so the PHY can drive the turnaround and data bits.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset, the word reads back with the PHY address field (bits 15:11) equal to the parameter PHY_ADDR_RST. All other bits read as zero: data 31:16, register address 10:6, not-valid bit 4 and busy bit 3. MDC is low and MDIO is not driven.
- R2: A write with bit 0 set and bit 1 clear, accepted while idle, sends a write frame MSB first. The frame is 32 ones, start 01, opcode 01, the PHY address from bits 15:11, the register address from bits 10:6, turnaround 10, then the 16 data bits from 31:16. MDIO is driven for the whole frame and released afterwards.
- R3: A write with bit 1 set sends 32 ones, start 01, opcode 10, the PHY address and the register address. The block then leaves MDIO undriven for the turnaround and all 16 data bit times.
- R4: In a read, the 16 bits the PHY presents after the turnaround are sampled on MDC rising edges, MSB first. They appear in bits 31:16 in the same cycle that busy clears.
- R5: The busy bit (bit 3) reads as one from the cycle after a command is accepted until the frame ends. MDIO is driven only while busy is set.
- R6: The not-valid bit (bit 4) is set when a read finds MDIO high during the second turnaround bit. Each accepted command clears it.
- R7: A write that arrives while busy is set has no effect: no field changes and no extra frame is sent.
- R8: MDC has a period of 2*CLK_DIV system clocks during a frame and stays low while idle.
- R9: When bits 1 and 0 are both written as one, a read is performed. Bits 2:0 always read back as zero.
- R10: A write while idle with bits 1:0 both zero loads the data and both address fields. It starts no frame, so MDC stays low and busy stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the command word |
| wr_data | input | 32 | Command word written by the host |
| rd_data | output | 32 | Command/status word read by the host |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdio_o | output | 1 | MDIO level driven by the block |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The assertions assume that the host follows the polling protocol, so a command written during busy is the only way the fields can be touched mid-frame. They also assume that MDIO input is stable around each sampling MDC rising edge. The bench's PHY model changes its drive only right after an MDC rising edge, which leaves a full MDC low phase before the next sample. It models the pull-up by reading an undriven line as one. The host tasks write one word per strobe and poll the busy bit to completion, and the busy-time write of R7 is issued on purpose.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  // frame layout, counted from the first bit on the wire
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = PRE_BITS + 2 + 2 + 5 + 5;  // index of first turnaround bit
  localparam int FRAME_BITS = HDR_BITS + 2 + 16;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  // command/status word layout
  localparam int WR_BIT   = 0;
  localparam int RD_BIT   = 1;
  localparam int BUSY_BIT = 3;
  localparam int NV_BIT   = 4;

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic rd,
                                                        input logic [4:0] pa,
                                                        input logic [4:0] ra,
                                                        input logic [15:0] wd);
    logic [1:0]  op;
    logic [1:0]  ta;
    logic [15:0] dt;
    op = rd ? 2'b10 : 2'b01;
    ta = rd ? 2'b11 : 2'b10;
    dt = rd ? 16'hFFFF : wd;
    return {{PRE_BITS{1'b1}}, 2'b01, op, pa, ra, ta, dt};
  endfunction
endpackage

// File: rtl/mdio_tick_gen.sv
`timescale 1ns/1ps
module mdio_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = en;
    end else begin : g_cnt
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || !en)       cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end

      assign tick = en && (cnt == LAST);

      // R8: half-periods are at least two system clocks apart
      a_r8_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        start_rd,
  input  logic [4:0]  pa,
  input  logic [4:0]  ra,
  input  logic [15:0] wd,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        busy,
  output logic        is_rd,
  output logic        fin,
  output logic [15:0] rdata,
  output logic        nvalid
);
  localparam logic [IDX_W-1:0] I_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] I_HDR  = IDX_W'(HDR_BITS);
  localparam logic [IDX_W-1:0] I_TA2  = IDX_W'(HDR_BITS + 1);
  localparam logic [IDX_W-1:0] I_PRE  = IDX_W'(PRE_BITS);

  logic                  tick;
  logic [IDX_W-1:0]      bit_idx;
  logic [IDX_W-1:0]      nxt_idx;
  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frame;

  mdio_tick_gen #(.DIV(DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .en  (busy),
    .tick(tick)
  );

  assign frame   = build_frame(start_rd, pa, ra, wd);
  assign nxt_idx = bit_idx + 1'b1;
  assign fin     = busy && tick && mdc && (bit_idx == I_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      mdc     <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      bit_idx <= '0;
      shreg   <= '0;
      rdata   <= '0;
      nvalid  <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        is_rd   <= start_rd;
        mdc     <= 1'b0;
        mdio_o  <= frame[FRAME_BITS-1];
        mdio_oe <= 1'b1;
        shreg   <= {frame[FRAME_BITS-2:0], 1'b0};
        bit_idx <= '0;
        nvalid  <= 1'b0;
        rdata   <= '0;
      end
    end else if (tick) begin
      if (!mdc) begin
        // rising MDC edge: sample the PHY during a read
        mdc <= 1'b1;
        if (is_rd) begin
          if (bit_idx == I_TA2 && mdio_i) nvalid <= 1'b1;
          if (bit_idx > I_TA2)            rdata  <= {rdata[14:0], mdio_i};
        end
      end else begin
        // falling MDC edge: present the next bit or finish
        mdc <= 1'b0;
        if (bit_idx == I_LAST) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
        end else begin
          bit_idx <= nxt_idx;
          mdio_o  <= shreg[FRAME_BITS-1];
          shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
          mdio_oe <= !(is_rd && (nxt_idx >= I_HDR));
        end
      end
    end
  end

  // R8: MDC is parked low between frames
  a_r8_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R3: the line is released for turnaround and data during a read
  a_r3_read_release: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && bit_idx >= I_HDR) |-> !mdio_oe);

  // R2: the preamble is driven as ones
  a_r2_preamble_ones: assert property (@(posedge clk) disable iff (rst)
    (busy && bit_idx < I_PRE) |-> (mdio_oe && mdio_o));
endmodule

// File: rtl/mdio_mgmt.sv
`timescale 1ns/1ps
module mdio_mgmt
  import mdio_pkg::*;
#(
  parameter int         CLK_DIV      = 4,
  parameter logic [4:0] PHY_ADDR_RST = 5'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [15:0] data_q;
  logic [4:0]  phy_q;
  logic [4:0]  reg_q;
  logic        nv_q;

  logic        busy;
  logic        eng_rd;
  logic        eng_fin;
  logic [15:0] eng_rdata;
  logic        eng_nv;

  logic accept;
  logic start;
  logic start_rd;
  logic unused_bits;

  assign accept      = wr_en && !busy;
  assign start_rd    = wr_data[RD_BIT];
  assign start       = accept && (wr_data[RD_BIT] || wr_data[WR_BIT]);
  assign unused_bits = ^wr_data[5:2];

  mdio_frame_eng #(.DIV(CLK_DIV)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .start_rd(start_rd),
    .pa      (wr_data[15:11]),
    .ra      (wr_data[10:6]),
    .wd      (wr_data[31:16]),
    .mdio_i  (mdio_i),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .busy    (busy),
    .is_rd   (eng_rd),
    .fin     (eng_fin),
    .rdata   (eng_rdata),
    .nvalid  (eng_nv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      phy_q  <= PHY_ADDR_RST;
      reg_q  <= '0;
      nv_q   <= 1'b0;
    end else if (accept) begin
      data_q <= wr_data[31:16];
      phy_q  <= wr_data[15:11];
      reg_q  <= wr_data[10:6];
      if (start) nv_q <= 1'b0;
    end else if (eng_fin && eng_rd) begin
      data_q <= eng_rdata;
      nv_q   <= eng_nv;
    end
  end

  assign rd_data = {data_q, phy_q, reg_q, 1'b0, nv_q, busy, 3'b000};

  // R7: address fields cannot move while a frame runs
  a_r7_fields_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(phy_q) && $stable(reg_q)));

  // R5: the line is only driven inside a busy window
  a_r5_drive_in_busy: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);

  // R6: a new command clears the not-valid flag
  a_r6_nv_cleared: assert property (@(posedge clk) disable iff (rst)
    start |=> !nv_q);

  // R5: busy rises right after a command is taken
  a_r5_busy_rise: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

// File: tb/sim_mdio_mgmt.sv
`timescale 1ns/1ps
module sim_mdio_mgmt;
  localparam int         DIV  = 2;
  localparam logic [4:0] BPHY = 5'd9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mdc;
  logic        mdio_i = 1'b1;
  logic        mdio_o;
  logic        mdio_oe;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  mdio_mgmt #(.CLK_DIV(DIV), .PHY_ADDR_RST(BPHY)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // cycle counter for MDC period measurement
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural PHY with pull-up on the line
  logic [15:0] phy_mem [32];
  logic [63:0] lg = '0;
  logic [63:0] last_frame = '0;
  logic [5:0]  k = '0;
  logic        cur_rd = 1'b0;
  logic        respond = 1'b0;
  logic        fault = 1'b0;
  logic [4:0]  raddr = '0;
  int frames = 0;
  int oe_viol = 0;
  int last_rise = 0;
  int per_min = 1000000;
  int per_max = 0;

  initial for (int i = 0; i < 32; i++) phy_mem[i] = 16'h0;

  always @(posedge mdc) begin
    logic bitv;
    if (k != 0) begin
      if (cyc - last_rise < per_min) per_min = cyc - last_rise;
      if (cyc - last_rise > per_max) per_max = cyc - last_rise;
    end
    last_rise = cyc;
    bitv = mdio_oe ? mdio_o : 1'b1;
    if (cur_rd && k >= 6'd46 && mdio_oe) oe_viol++;
    lg = {lg[62:0], bitv};
    if (k == 6'd45) begin
      cur_rd  = (lg[11:10] == 2'b10);
      respond = cur_rd && (lg[9:5] == BPHY);
      raddr   = lg[4:0];
      mdio_i  = 1'b1;
    end else if (k == 6'd46) begin
      mdio_i = (respond && !fault) ? 1'b0 : 1'b1;
    end else if (k >= 6'd47 && k <= 6'd62) begin
      mdio_i = respond ? phy_mem[raddr][62 - int'(k)] : 1'b1;
    end else if (k == 6'd63) begin
      mdio_i = 1'b1;
      frames++;
      last_frame = lg;
      if (lg[29:28] == 2'b01 && lg[27:23] == BPHY && lg[17:16] == 2'b10)
        phy_mem[lg[22:18]] = lg[15:0];
      cur_rd = 1'b0;
    end
    k = k + 6'd1;
  end

  function automatic logic [15:0] pat(input int r);
    return 16'((r * 32'h0813) ^ 32'h5A00);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000; i++) begin
      if (!rd_data[3]) break;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R5 watchdog expired actual=%0d expected=0", rd_data[3]);
    summary();
    $finish;
  end

  initial begin
    int f0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(rd_data == {16'h0, BPHY, 5'd0, 6'd0}, "R1 reset word", rd_data, {16'h0, BPHY, 5'd0, 6'd0});
    chk(!mdc && !mdio_oe, "R1 lines idle", {mdc, mdio_oe}, 0);

    // R10 field load without an operation
    host_wr({16'hABCD, 5'd3, 5'd7, 6'b000000});
    repeat (40) @(negedge clk);
    chk(rd_data == {16'hABCD, 5'd3, 5'd7, 6'd0}, "R10 fields loaded", rd_data, {16'hABCD, 5'd3, 5'd7, 6'd0});
    chk(frames == 0 && !mdc, "R10 no frame", frames, 0);

    // R2 write sweep over every register address
    for (int r = 0; r < 32; r++) begin
      host_wr({pat(r), BPHY, 5'(r), 6'b000001});
      chk(rd_data[3] == 1'b1, "R5 busy after write cmd", rd_data[3], 1);
      chk(rd_data[2:0] == 3'b000, "R9 low bits read zero", rd_data[2:0], 0);
      wait_idle();
      chk(last_frame == {32'hFFFF_FFFF, 2'b01, 2'b01, BPHY, 5'(r), 2'b10, pat(r)},
          "R2 write frame", last_frame, {32'hFFFF_FFFF, 2'b01, 2'b01, BPHY, 5'(r), 2'b10, pat(r)});
      chk(!mdio_oe, "R2 released after frame", mdio_oe, 0);
    end

    // R3/R4 read sweep
    for (int r = 0; r < 32; r++) begin
      host_wr({16'h0, BPHY, 5'(r), 6'b000010});
      wait_idle();
      chk(rd_data[31:16] == pat(r), "R4 read data", rd_data[31:16], pat(r));
      chk(rd_data[4] == 1'b0, "R6 valid read", rd_data[4], 0);
      chk(last_frame[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, BPHY, 5'(r)}, "R3 read header",
          last_frame[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, BPHY, 5'(r)});
    end
    chk(oe_viol == 0, "R3 line released in read", oe_viol, 0);

    // R6 absent PHYs give not-valid
    for (int p = 0; p < 32; p++) begin
      if (5'(p) == BPHY) continue;
      host_wr({16'h0, 5'(p), 5'd0, 6'b000010});
      wait_idle();
      chk(rd_data[4] == 1'b1, "R6 absent phy not-valid", rd_data[4], 1);
      chk(rd_data[31:16] == 16'hFFFF, "R4 absent phy data", rd_data[31:16], 16'hFFFF);
    end

    // R6 turnaround fault, then clearing on next command
    fault = 1'b1;
    host_wr({16'h0, BPHY, 5'd5, 6'b000010});
    wait_idle();
    chk(rd_data[4] == 1'b1, "R6 turnaround fault", rd_data[4], 1);
    fault = 1'b0;
    host_wr({pat(5), BPHY, 5'd5, 6'b000001});
    chk(rd_data[4] == 1'b0, "R6 cleared on command", rd_data[4], 0);
    wait_idle();

    // R7 command during busy is ignored
    f0 = frames;
    host_wr({16'h0, BPHY, 5'd2, 6'b000010});
    repeat (10) @(negedge clk);
    host_wr({16'h1234, 5'd1, 5'd1, 6'b000001});
    chk(rd_data[15:6] == {BPHY, 5'd2}, "R7 fields held while busy", rd_data[15:6], {BPHY, 5'd2});
    wait_idle();
    repeat (300) @(negedge clk);
    chk(frames == f0 + 1, "R7 single frame", frames, f0 + 1);
    chk(rd_data[31:6] == {pat(2), BPHY, 5'd2}, "R7 result unaffected", rd_data[31:6], {pat(2), BPHY, 5'd2});

    // R9 both operation bits -> read
    host_wr({16'h0, BPHY, 5'd4, 6'b000011});
    chk(rd_data[3] && rd_data[1:0] == 2'b00, "R9 busy and zero op bits", rd_data[3:0], 4'b1000);
    wait_idle();
    chk(last_frame[29:28] == 2'b10, "R9 opcode is read", last_frame[29:28], 2'b10);
    chk(rd_data[31:16] == pat(4), "R9 read data", rd_data[31:16], pat(4));

    // R8 MDC period and idle level
    chk(per_min == 2 * DIV && per_max == 2 * DIV, "R8 mdc period", {per_min[31:0], per_max[31:0]}, {32'(2 * DIV), 32'(2 * DIV)});
    chk(!mdc, "R8 mdc idle low", mdc, 0);

    summary();
    $finish;
  end
endmodule